// File: doc/BRIEF.md
# Latency-Hiding Warp Issue Scheduler

This block picks, in every clock cycle, one warp out of a pool of resident warps and issues that warp's next instruction. A warp is a group of 32 threads that is always scheduled as one unit. The block never issues part of a warp. When the issued instruction is a load to long-latency memory, the block parks the warp: the warp is flagged as waiting and drops out of selection. The issue slot goes to some other ready warp in the next cycle. No context is saved or restored, because the register state of every resident warp stays live. A completion port names the warp whose load has returned, and that warp becomes selectable again.

Many warps can be waiting at once, one outstanding load per warp, so latency of hundreds of cycles is covered as long as some warp is still ready. Selection among eligible warps is round-robin and starts just after the last warp that issued. A cycle in which no warp can issue drives the issue-valid output low and adds one to a stall counter.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is applied the stall count reads 0, and no warp is waiting. After reset the first pick is the lowest-numbered eligible warp, searching from warp 0.
- R2: A warp is eligible only when its resident bit, its valid bit and its ready bit are all 1 and it is not waiting. issue_valid_o is 1 exactly when at least one warp is eligible.
- R3: The issued warp is the first eligible warp at an index above the last warp that issued. When no eligible warp has a higher index, the search wraps to index 0.
- R4: A warp issued with its load flag at 1 is waiting from the next cycle on and is not issued again until a completion names it. A warp issued with its load flag at 0 does not become waiting.
- R5: A completion (cmpl_valid_i at 1 with cmpl_warp_i equal to w) clears w's waiting state. w may issue in the same cycle as the completion.
- R6: If warp w issues a new load in the same cycle as a completion for w, the new load wins and w is waiting in the next cycle.
- R7: Several warps may be waiting at the same time. A completion for one of them does not release the others.
- R8: In a cycle with no eligible warp, issue_valid_o is 0 and stall_cnt_o has grown by exactly 1 after the next clock edge. In an issue cycle stall_cnt_o is unchanged. The last-issued position is kept across stall cycles.
- R9: A warp whose resident bit is 0 is never issued, even when its valid and ready bits are 1.
- R10: issue_load_o is 1 only in an issue cycle whose issued warp has its load flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released through an internal two-flop synchronizer |
| resident_i | input | NUM_WARPS | Bit w at 1 means slot w holds a resident warp |
| warp_valid_i | input | NUM_WARPS | Bit w at 1 means warp w has an instruction waiting to issue |
| warp_ready_i | input | NUM_WARPS | Bit w at 1 means warp w's instruction has its operands available |
| load_flag_i | input | NUM_WARPS | Bit w at 1 means warp w's pending instruction is a long-latency load |
| cmpl_valid_i | input | 1 | A load has completed this cycle |
| cmpl_warp_i | input | WID_W | Warp ID of the completed load |
| issue_valid_o | output | 1 | A warp issues this cycle |
| issue_warp_o | output | WID_W | ID of the issued warp |
| issue_load_o | output | 1 | The issued instruction is a long-latency load |
| stall_cnt_o | output | STALL_CNT_W | Number of cycles with no eligible warp since reset, wrapping |

## Verification
If a waiting flag is set wrongly, the warp vanishes from the issue stream in the very next cycle. That shows up as a skipped warp in a round-robin sequence, or as a stall where an issue was expected. If a flag is cleared wrongly, a parked warp issues again before its completion, also one cycle after the fault. If the round-robin pointer is wrong, the issued ID at the first pick after the fault differs from the expected one. A counting fault shows up in stall_cnt_o one edge after the stall cycle.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  // Threads carried by one warp; the scheduler always moves all of them.
  localparam int unsigned THREADS_PER_WARP = 32;

  // Upper bound on resident warps in one scheduler group.
  localparam int unsigned MAX_WARPS = 64;

  // Which half of the circular search produced the grant.
  typedef enum logic [1:0] {
    PICK_NONE  = 2'd0,
    PICK_UPPER = 2'd1,
    PICK_WRAP  = 2'd2
  } pick_src_e;

endpackage

// File: rtl/sched_rst_sync.sv
module sched_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_ok = stage2_q;

endmodule

// File: rtl/sched_wait_table.sv
module sched_wait_table #(
  parameter  int NUM_WARPS = 64,
  localparam int WID_W     = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_ok,
  input  logic                 park_en,
  input  logic [WID_W-1:0]     park_warp,
  input  logic                 wake_en,
  input  logic [WID_W-1:0]     wake_warp,
  output logic [NUM_WARPS-1:0] waiting_o
);

  logic [NUM_WARPS-1:0] park_hit;
  logic [NUM_WARPS-1:0] wake_hit;
  logic [NUM_WARPS-1:0] wait_d;
  logic [NUM_WARPS-1:0] wait_q;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    // decode of the two request ports for this slot
    assign park_hit[w] = park_en && (park_warp == WID_W'(w));
    assign wake_hit[w] = wake_en && (wake_warp == WID_W'(w));

    // a new park beats a same-cycle wake
    always_comb begin
      wait_d[w] = wait_q[w];
      if (wake_hit[w]) wait_d[w] = 1'b0;
      if (park_hit[w]) wait_d[w] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_ok) begin
      if (!rst_ok) wait_q[w] <= 1'b0;
      else         wait_q[w] <= wait_d[w];
    end
  end

  assign waiting_o = wait_q;

endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick
  import warp_sched_pkg::*;
#(
  parameter  int NUM_WARPS = 64,
  localparam int WID_W     = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_ok,
  input  logic [NUM_WARPS-1:0] req,
  output logic                 gnt_valid,
  output logic [WID_W-1:0]     gnt_idx
);

  logic [WID_W-1:0] last_q;
  logic [WID_W-1:0] last_d;
  logic [WID_W-1:0] upper_idx;
  logic [WID_W-1:0] wrap_idx;
  logic             upper_found;
  logic             wrap_found;
  pick_src_e        src;

  // lowest request above the last grant, and lowest request overall
  always_comb begin
    upper_found = 1'b0;
    wrap_found  = 1'b0;
    upper_idx   = '0;
    wrap_idx    = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (req[i] && !wrap_found) begin
        wrap_found = 1'b1;
        wrap_idx   = WID_W'(i);
      end
      if (req[i] && !upper_found && (WID_W'(i) > last_q)) begin
        upper_found = 1'b1;
        upper_idx   = WID_W'(i);
      end
    end
  end

  always_comb begin
    if (upper_found)     src = PICK_UPPER;
    else if (wrap_found) src = PICK_WRAP;
    else                 src = PICK_NONE;
  end

  always_comb begin
    gnt_valid = 1'b1;
    gnt_idx   = '0;
    unique case (src)
      PICK_UPPER: gnt_idx = upper_idx;
      PICK_WRAP:  gnt_idx = wrap_idx;
      default:    gnt_valid = 1'b0;
    endcase
  end

  // pointer enable: advance only on a grant
  always_comb begin
    last_d = last_q;
    if (gnt_valid) last_d = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) last_q <= WID_W'(NUM_WARPS - 1);
    else         last_q <= last_d;
  end

endmodule

// File: rtl/sched_stall_ctr.sv
module sched_stall_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_ok,
  input  logic             stall_en,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (stall_en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter  int NUM_WARPS   = 64,
  parameter  int STALL_CNT_W = 32,
  localparam int WID_W       = $clog2(NUM_WARPS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_WARPS-1:0]   resident_i,
  input  logic [NUM_WARPS-1:0]   warp_valid_i,
  input  logic [NUM_WARPS-1:0]   warp_ready_i,
  input  logic [NUM_WARPS-1:0]   load_flag_i,
  input  logic                   cmpl_valid_i,
  input  logic [WID_W-1:0]       cmpl_warp_i,
  output logic                   issue_valid_o,
  output logic [WID_W-1:0]       issue_warp_o,
  output logic                   issue_load_o,
  output logic [STALL_CNT_W-1:0] stall_cnt_o
);

  logic                 rst_ok;
  logic [NUM_WARPS-1:0] waiting;
  logic [NUM_WARPS-1:0] wake_vec;
  logic [NUM_WARPS-1:0] eligible;
  logic                 gnt_valid;
  logic [WID_W-1:0]     gnt_idx;
  logic                 park_en;

  sched_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  // a completion releases its warp in the same cycle (wake bypass)
  assign wake_vec = cmpl_valid_i ? (NUM_WARPS'(1) << cmpl_warp_i) : '0;

  assign eligible = rst_ok ? (resident_i & warp_valid_i & warp_ready_i &
                              (~waiting | wake_vec))
                           : '0;

  sched_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
    .clk       (clk),
    .rst_ok    (rst_ok),
    .req       (eligible),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  assign park_en = gnt_valid && load_flag_i[gnt_idx];

  sched_wait_table #(.NUM_WARPS(NUM_WARPS)) u_wait (
    .clk       (clk),
    .rst_ok    (rst_ok),
    .park_en   (park_en),
    .park_warp (gnt_idx),
    .wake_en   (cmpl_valid_i),
    .wake_warp (cmpl_warp_i),
    .waiting_o (waiting)
  );

  sched_stall_ctr #(.CNT_W(STALL_CNT_W)) u_stall (
    .clk      (clk),
    .rst_ok   (rst_ok),
    .stall_en (!gnt_valid),
    .count_o  (stall_cnt_o)
  );

  assign issue_valid_o = gnt_valid;
  assign issue_warp_o  = gnt_idx;
  assign issue_load_o  = park_en;

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter  int NUM_WARPS   = 64,
  parameter  int STALL_CNT_W = 32,
  localparam int WID_W       = $clog2(NUM_WARPS)
) (
  input logic                   clk,
  input logic                   rst_ok,
  input logic [NUM_WARPS-1:0]   resident_i,
  input logic [NUM_WARPS-1:0]   warp_valid_i,
  input logic [NUM_WARPS-1:0]   warp_ready_i,
  input logic                   cmpl_valid_i,
  input logic [WID_W-1:0]       cmpl_warp_i,
  input logic                   issue_valid_o,
  input logic [WID_W-1:0]       issue_warp_o,
  input logic                   issue_load_o,
  input logic [STALL_CNT_W-1:0] stall_cnt_o
);

  AST_ISSUE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_ok)
    issue_valid_o |-> (resident_i[issue_warp_o] && warp_valid_i[issue_warp_o] &&
                       warp_ready_i[issue_warp_o])); // R9

  AST_NO_CANDIDATE_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    ((resident_i & warp_valid_i & warp_ready_i) == '0) |-> !issue_valid_o); // R2

  AST_LOAD_PARKS: assert property (@(posedge clk) disable iff (!rst_ok)
    (issue_valid_o && issue_load_o) |=>
      !(issue_valid_o && (issue_warp_o == $past(issue_warp_o)) &&
        !(cmpl_valid_i && (cmpl_warp_i == $past(issue_warp_o))))); // R4

  AST_LOAD_BEATS_WAKE: assert property (@(posedge clk) disable iff (!rst_ok)
    (issue_valid_o && issue_load_o && cmpl_valid_i && (cmpl_warp_i == issue_warp_o)) |=>
      !(issue_valid_o && (issue_warp_o == $past(issue_warp_o)) &&
        !(cmpl_valid_i && (cmpl_warp_i == $past(issue_warp_o))))); // R6

  AST_STALL_COUNTS: assert property (@(posedge clk) disable iff (!rst_ok)
    !issue_valid_o |=> (stall_cnt_o == $past(stall_cnt_o) + STALL_CNT_W'(1))); // R8

  AST_ISSUE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_ok)
    issue_valid_o |=> $stable(stall_cnt_o)); // R8

  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_ok)
    !issue_valid_o |-> !issue_load_o); // R10

endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS   (NUM_WARPS),
  .STALL_CNT_W (STALL_CNT_W)
) u_chk (
  .clk           (clk),
  .rst_ok        (rst_ok),
  .resident_i    (resident_i),
  .warp_valid_i  (warp_valid_i),
  .warp_ready_i  (warp_ready_i),
  .cmpl_valid_i  (cmpl_valid_i),
  .cmpl_warp_i   (cmpl_warp_i),
  .issue_valid_o (issue_valid_o),
  .issue_warp_o  (issue_warp_o),
  .issue_load_o  (issue_load_o),
  .stall_cnt_o   (stall_cnt_o)
);

// File: tb/warp_issue_sched_tb.sv
`timescale 1ns/1ps
module warp_issue_sched_tb;

  localparam int N  = 64;
  localparam int WW = 6;
  localparam int CW = 32;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  resident_i;
  logic [N-1:0]  warp_valid_i;
  logic [N-1:0]  warp_ready_i;
  logic [N-1:0]  load_flag_i;
  logic          cmpl_valid_i;
  logic [WW-1:0] cmpl_warp_i;
  logic          issue_valid_o;
  logic [WW-1:0] issue_warp_o;
  logic          issue_load_o;
  logic [CW-1:0] stall_cnt_o;

  int n_checks;
  int n_fail;
  int snap;

  warp_issue_sched #(.NUM_WARPS(N), .STALL_CNT_W(CW)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .resident_i    (resident_i),
    .warp_valid_i  (warp_valid_i),
    .warp_ready_i  (warp_ready_i),
    .load_flag_i   (load_flag_i),
    .cmpl_valid_i  (cmpl_valid_i),
    .cmpl_warp_i   (cmpl_warp_i),
    .issue_valid_o (issue_valid_o),
    .issue_warp_o  (issue_warp_o),
    .issue_load_o  (issue_load_o),
    .stall_cnt_o   (stall_cnt_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [N-1:0] bit_of(input int w);
    return N'(1) << w;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // next cycle: drive at the falling edge, settle, then observe
  task automatic drive(input logic [N-1:0] res, input logic [N-1:0] val,
                       input logic [N-1:0] rdy, input logic [N-1:0] ld,
                       input logic cv, input int cw);
    @(negedge clk);
    resident_i   = res;
    warp_valid_i = val;
    warp_ready_i = rdy;
    load_flag_i  = ld;
    cmpl_valid_i = cv;
    cmpl_warp_i  = WW'(cw);
    #1;
  endtask

  task automatic expect_issue(input string tag, input int warp, input logic ld);
    check({tag, " valid"}, int'(issue_valid_o), 1);
    check({tag, " warp"},  int'(issue_warp_o), warp);
    check({tag, " load"},  int'(issue_load_o), int'(ld));
  endtask

  task automatic expect_stall(input string tag);
    check({tag, " valid"}, int'(issue_valid_o), 0);
    check({tag, " load"},  int'(issue_load_o), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n        = 1'b0;
    resident_i   = '0;
    warp_valid_i = '0;
    warp_ready_i = '0;
    load_flag_i  = '0;
    cmpl_valid_i = 1'b0;
    cmpl_warp_i  = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  localparam logic [N-1:0] ALL = '1;

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 stall count in reset", int'(stall_cnt_o), 0);
    check("R1 no issue in reset", int'(issue_valid_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // every warp eligible: first pick must be warp 0
    drive(ALL, ALL, ALL, '0, 1'b0, 0);
    expect_issue("R1 first pick", 0, 1'b0);
  endtask

  task automatic t_stall_count();
    do_reset();
    drive(ALL, '0, ALL, '0, 1'b0, 0);
    snap = int'(stall_cnt_o);
    expect_stall("R8 empty pool");
    drive(ALL, '0, ALL, '0, 1'b0, 0);
    check("R8 count +1", int'(stall_cnt_o), snap + 1);
    drive(ALL, bit_of(7), ALL, '0, 1'b0, 0);
    check("R8 count +2", int'(stall_cnt_o), snap + 2);
    expect_issue("R8 issue after stalls", 7, 1'b0);
    drive(ALL, bit_of(7), ALL, '0, 1'b0, 0);
    check("R8 count held on issue", int'(stall_cnt_o), snap + 2);
    // pointer kept across a stall: last = 7, eligible {3,9} -> 9
    drive(ALL, '0, ALL, '0, 1'b0, 0);
    drive(ALL, bit_of(3) | bit_of(9), ALL, '0, 1'b0, 0);
    expect_issue("R8 pointer kept", 9, 1'b0);
  endtask

  task automatic t_round_robin();
    logic [N-1:0] v;
    do_reset();
    v = bit_of(0) | bit_of(1) | bit_of(2);
    drive(ALL, v, ALL, '0, 1'b0, 0); expect_issue("R3 rr a", 0, 1'b0);
    drive(ALL, v, ALL, '0, 1'b0, 0); expect_issue("R3 rr b", 1, 1'b0);
    drive(ALL, v, ALL, '0, 1'b0, 0); expect_issue("R3 rr c", 2, 1'b0);
    drive(ALL, v, ALL, '0, 1'b0, 0); expect_issue("R3 rr d", 0, 1'b0);
    v = bit_of(3) | bit_of(63);
    drive(ALL, v, ALL, '0, 1'b0, 0); expect_issue("R3 wrap a", 3, 1'b0);
    drive(ALL, v, ALL, '0, 1'b0, 0); expect_issue("R3 wrap b", 63, 1'b0);
    drive(ALL, v, ALL, '0, 1'b0, 0); expect_issue("R3 wrap c", 3, 1'b0);
  endtask

  task automatic t_eligibility();
    logic [N-1:0] v;
    logic [N-1:0] res;
    logic [N-1:0] rdy;
    do_reset();
    v   = bit_of(5) | bit_of(6) | bit_of(7) | bit_of(8);
    res = ALL & ~bit_of(6);
    rdy = ALL & ~bit_of(7);
    drive(res, v, rdy, '0, 1'b0, 0); expect_issue("R2 qualified a", 5, 1'b0);
    drive(res, v, rdy, '0, 1'b0, 0); expect_issue("R2 qualified b", 8, 1'b0);
    drive(res, v, rdy, '0, 1'b0, 0); expect_issue("R2 qualified c", 5, 1'b0);
    drive(res, bit_of(6), ALL, '0, 1'b0, 0);
    expect_stall("R9 non-resident ignored");
    drive(ALL, bit_of(7), rdy, '0, 1'b0, 0);
    expect_stall("R2 not ready ignored");
  endtask

  task automatic t_load_park();
    logic [N-1:0] v;
    do_reset();
    v = bit_of(4) | bit_of(9);
    drive(ALL, v, ALL, bit_of(4), 1'b0, 0); expect_issue("R10 load issue", 4, 1'b1);
    drive(ALL, v, ALL, bit_of(4), 1'b0, 0); expect_issue("R4 switch away", 9, 1'b0);
    drive(ALL, v, ALL, bit_of(4), 1'b0, 0); expect_issue("R4 parked skipped", 9, 1'b0);
    drive(ALL, bit_of(4), ALL, '0, 1'b0, 0); expect_stall("R4 parked alone");
    drive(ALL, bit_of(9), ALL, '0, 1'b0, 0); expect_issue("R4 non-load stays", 9, 1'b0);
    drive(ALL, bit_of(9), ALL, '0, 1'b0, 0); expect_issue("R4 non-load again", 9, 1'b0);
  endtask

  task automatic t_multi_wake();
    logic [N-1:0] v;
    do_reset();
    v = bit_of(1) | bit_of(2) | bit_of(3);
    drive(ALL, v, ALL, v, 1'b0, 0); expect_issue("R7 load 1", 1, 1'b1);
    drive(ALL, v, ALL, v, 1'b0, 0); expect_issue("R7 load 2", 2, 1'b1);
    drive(ALL, v, ALL, v, 1'b0, 0); expect_issue("R7 load 3", 3, 1'b1);
    drive(ALL, v, ALL, v, 1'b0, 0); expect_stall("R7 all parked");
    drive(ALL, v, ALL, '0, 1'b1, 2); expect_issue("R5 bypass wake", 2, 1'b0);
    drive(ALL, v, ALL, '0, 1'b0, 0); expect_issue("R5 flag cleared", 2, 1'b0);
    drive(ALL, v, ALL, '0, 1'b1, 1); expect_issue("R7 wake 1", 1, 1'b0);
    drive(ALL, v, ALL, '0, 1'b0, 0); expect_issue("R7 3 still parked a", 2, 1'b0);
    drive(ALL, v, ALL, '0, 1'b0, 0); expect_issue("R7 3 still parked b", 1, 1'b0);
  endtask

  task automatic t_load_beats_wake();
    do_reset();
    drive(ALL, bit_of(6), ALL, bit_of(6), 1'b0, 0); expect_issue("R6 first load", 6, 1'b1);
    drive(ALL, bit_of(6), ALL, bit_of(6), 1'b1, 6); expect_issue("R6 load with wake", 6, 1'b1);
    drive(ALL, bit_of(6), ALL, '0, 1'b0, 0); expect_stall("R6 still parked");
    drive(ALL, bit_of(6), ALL, '0, 1'b1, 6); expect_issue("R6 later wake", 6, 1'b0);
    drive(ALL, bit_of(6), ALL, '0, 1'b0, 0); expect_issue("R6 free again", 6, 1'b0);
  endtask

  initial begin
    n_checks     = 0;
    n_fail       = 0;
    rst_n        = 1'b0;
    resident_i   = '0;
    warp_valid_i = '0;
    warp_ready_i = '0;
    load_flag_i  = '0;
    cmpl_valid_i = 1'b0;
    cmpl_warp_i  = '0;
    t_reset();
    t_stall_count();
    t_round_robin();
    t_eligibility();
    t_load_park();
    t_multi_wake();
    t_load_beats_wake();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule